// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address with 4 KB pages into a physical page number by walking a two-level table in memory. The virtual address is cut into three fields: the top 10 bits select an entry in the first-level table, the next 10 bits select an entry in a second-level table, and the low 12 bits are the page offset, which the walker does not use. The first-level table sits in the physical page held by the walker's base register. That register is reloaded by the surrounding logic whenever the running process changes.

A request carries a virtual address and an access type. The walker reads the first-level entry through a single memory read port. If that entry is valid, it reads the second-level entry from the page the first entry names. It then checks validity and access rights, and returns either the physical page number or a fault of one of three kinds. A successful walk also pulses a fill record: virtual page, physical page and rights. A translation cache can load that record so the next access to the page needs no walk. Only one walk is in flight at a time, and a busy flag holds off new requests.

Table entries are 32 bits wide. Bit 0 is the valid flag, bits 2:1 are the rights field and bits 31:12 are a physical page number. In a first-level entry, that page number is the page holding the second-level table.

Top module: `page_walker`

## Requirements
- R1: After reset, busy, mem_req_valid, res_valid and fill_valid are all low, and the base register holds page 0.
- R2: The first memory read of a walk is at address base_page×4096 + vaddr[31:22]×4. The base page is the one the register held in the cycle the request was accepted.
- R3: The second read is at address L1[31:12]×4096 + vaddr[21:12]×4, where L1 is the first-level entry that was returned.
- R4: If bit 0 of the first-level entry is 0, the walk ends with res_fault=1 and res_kind=01 after exactly one memory read.
- R5: If bit 0 of the second-level entry is 0, the walk ends with res_fault=1 and res_kind=10 after exactly two reads.
- R6: The rights field (entry bits 2:1) is coded 00 none, 01 read-only, 10 read/write, 11 read/execute. The access type is coded 00 read, 01 write, 10 execute, 11 reserved. A read needs any rights other than 00, a write needs 10, an execute needs 11, and a reserved access is never allowed. A valid second-level entry whose rights forbid the access ends the walk with res_fault=1 and res_kind=11. The rights of a first-level entry are ignored.
- R7: On success, res_fault=0, res_kind=00 and res_ppn = L2[31:12]. In the same cycle fill_valid=1 with fill_vpn=vaddr[31:12], fill_ppn=L2[31:12] and fill_rights=L2[2:1].
- R8: A pulse on base_load stores base_page. Walks accepted afterwards use the new value; a walk already running keeps the base it started with.
- R9: A request is accepted only while busy is low. busy rises in the next cycle and stays high until the cycle after the result. A request raised while busy is ignored.
- R10: res_valid is a one-cycle pulse per accepted request, and fill_valid never rises on a faulting walk.
- R11: mem_req_valid is low while busy is low. Once raised, mem_req_valid and mem_req_addr hold steady until mem_req_ready. At most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_load | input | 1 | Load the table base register |
| base_page | input | 20 | Physical page of the first-level table |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | Access type: 00 read, 01 write, 10 execute, 11 reserved |
| busy | output | 1 | Walk in progress, requests ignored |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Result pulse |
| res_fault | output | 1 | Walk ended in a fault |
| res_kind | output | 2 | 00 ok, 01 first level invalid, 10 second level invalid, 11 rights violation |
| res_ppn | output | 20 | Translated physical page number |
| fill_valid | output | 1 | Fill record for a translation cache |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_ppn | output | 20 | Physical page number of the fill |
| fill_rights | output | 2 | Rights field of the fill |

## Verification
The inline assertions check the handshake rules on every cycle: a held read request and its address stay stable, no read is requested while idle, busy rises only after a request, and the result pulse lasts one cycle and is followed by idle. The bench alone can show that the address arithmetic at both levels is correct, that each fault kind comes from the right entry with the right number of reads, and that the rights table matches each access type. It also shows that a base reload during a walk takes effect only on the next walk, and that a request raised while busy leaves no trace.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int PTE_W  = 32;
    localparam int PPN_W  = PTE_W - OFF_W;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int RGT_W  = 2;
    localparam int ACC_W  = 2;

    typedef enum logic [2:0] {
        ST_IDLE, ST_RD1, ST_WT1, ST_RD2, ST_WT2, ST_DONE, ST_FAULT
    } walk_state_t;

    typedef enum logic [1:0] {
        FK_NONE = 2'b00, FK_LVL1 = 2'b01, FK_LVL2 = 2'b10, FK_PROT = 2'b11
    } fault_kind_t;

    typedef enum logic [ACC_W-1:0] {
        ACC_READ = 2'b00, ACC_WRITE = 2'b01, ACC_EXEC = 2'b10, ACC_RSVD = 2'b11
    } access_t;

    typedef enum logic [RGT_W-1:0] {
        RG_NONE = 2'b00, RG_RO = 2'b01, RG_RW = 2'b10, RG_RX = 2'b11
    } rights_t;

    typedef struct packed {
        logic [PPN_W-1:0] ppn;
        logic [OFF_W-RGT_W-2:0] spare;
        rights_t          rights;
        logic             valid;
    } pte_t;

    function automatic logic access_allowed(rights_t r, access_t a);
        case (a)
            ACC_READ:  return r != RG_NONE;
            ACC_WRITE: return r == RG_RW;
            ACC_EXEC:  return r == RG_RX;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [PPN_W-1:0] value,
    output logic [PPN_W-1:0] base
);
    always_ff @(posedge clk) begin
        if (rst)       base <= '0;
        else if (load) base <= value;
    end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic             second,
    input  logic [PPN_W-1:0] root_page,
    input  logic [PPN_W-1:0] leaf_page,
    input  logic [VA_W-1:0]  vaddr,
    output logic [PTE_W-1:0] addr
);
    localparam int ESZ_W = $clog2(PTE_W / 8);

    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;
    logic [PPN_W-1:0] page;
    logic [IDX_W-1:0] idx;

    always_comb begin
        hi_idx = vaddr[VA_W-1 -: IDX_W];
        lo_idx = vaddr[OFF_W +: IDX_W];
        page   = second ? leaf_page : root_page;
        idx    = second ? lo_idx : hi_idx;
        addr   = {page, {(OFF_W-IDX_W-ESZ_W){1'b0}}, idx, {ESZ_W{1'b0}}};
    end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
    import ptw_pkg::*;
(
    input  logic [PTE_W-1:0] raw,
    input  access_t          access,
    output logic             present,
    output logic             permitted,
    output logic [PPN_W-1:0] page,
    output rights_t          rights
);
    pte_t e;
    always_comb begin
        e         = pte_t'(raw);
        present   = e.valid;
        rights    = e.rights;
        page      = e.ppn;
        permitted = access_allowed(e.rights, access);
    end
endmodule

// File: rtl/page_walker.sv
module page_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             base_load,
    input  logic [PPN_W-1:0] base_page,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [ACC_W-1:0] req_access,
    output logic             busy,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [PTE_W-1:0] mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             res_valid,
    output logic             res_fault,
    output logic [1:0]       res_kind,
    output logic [PPN_W-1:0] res_ppn,
    output logic             fill_valid,
    output logic [VPN_W-1:0] fill_vpn,
    output logic [PPN_W-1:0] fill_ppn,
    output logic [RGT_W-1:0] fill_rights
);
    walk_state_t      state, nxt;
    logic [PPN_W-1:0] base_cur, base_q, leaf_q, ppn_q;
    logic [VA_W-1:0]  va_q;
    access_t          acc_q;
    rights_t          rgt_q, chk_rights;
    fault_kind_t      kind_q;
    logic             chk_present, chk_permit;
    logic [PPN_W-1:0] chk_page;

    ptw_base_reg u_base (
        .clk(clk), .rst(rst), .load(base_load), .value(base_page), .base(base_cur)
    );

    ptw_addr_gen u_addr (
        .second(state == ST_RD2), .root_page(base_q), .leaf_page(leaf_q),
        .vaddr(va_q), .addr(mem_req_addr)
    );

    ptw_pte_check u_chk (
        .raw(mem_rsp_data), .access(acc_q), .present(chk_present),
        .permitted(chk_permit), .page(chk_page), .rights(chk_rights)
    );

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:  if (req_valid) nxt = ST_RD1;
            ST_RD1:   if (mem_req_ready) nxt = ST_WT1;
            ST_WT1:   if (mem_rsp_valid) nxt = chk_present ? ST_RD2 : ST_FAULT;
            ST_RD2:   if (mem_req_ready) nxt = ST_WT2;
            ST_WT2:   if (mem_rsp_valid)
                          nxt = (chk_present && chk_permit) ? ST_DONE : ST_FAULT;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            va_q   <= '0;
            acc_q  <= ACC_READ;
            base_q <= '0;
            leaf_q <= '0;
            ppn_q  <= '0;
            rgt_q  <= RG_NONE;
            kind_q <= FK_NONE;
        end else begin
            state <= nxt;
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    acc_q  <= access_t'(req_access);
                    base_q <= base_cur;
                    kind_q <= FK_NONE;
                    ppn_q  <= '0;
                    rgt_q  <= RG_NONE;
                end
                ST_WT1: if (mem_rsp_valid) begin
                    leaf_q <= chk_page;
                    if (!chk_present) kind_q <= FK_LVL1;
                end
                ST_WT2: if (mem_rsp_valid) begin
                    if (!chk_present)     kind_q <= FK_LVL2;
                    else if (!chk_permit) kind_q <= FK_PROT;
                    else begin
                        ppn_q <= chk_page;
                        rgt_q <= chk_rights;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        busy          = state != ST_IDLE;
        mem_req_valid = (state == ST_RD1) || (state == ST_RD2);
        res_valid     = (state == ST_DONE) || (state == ST_FAULT);
        res_fault     = state == ST_FAULT;
        res_kind      = kind_q;
        res_ppn       = ppn_q;
        fill_valid    = state == ST_DONE;
        fill_vpn      = va_q[VA_W-1:OFF_W];
        fill_ppn      = ppn_q;
        fill_rights   = rgt_q;
    end

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req_valid);

    // R9
    busy_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(req_valid));

    // R10
    res_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid && !busy);

    // R10
    fill_clean_chk: assert property (@(posedge clk) disable iff (rst)
        fill_valid |-> res_kind == FK_NONE);
endmodule

// File: tb/page_walker_test.sv
module page_walker_test;
    logic        clk = 0;
    logic        rst = 1;
    logic        base_load = 0;
    logic [19:0] base_page = '0;
    logic        req_valid = 0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic        busy, mem_req_valid, mem_req_ready = 0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid, res_fault, fill_valid;
    logic [1:0]  res_kind, fill_rights;
    logic [19:0] res_ppn, fill_vpn, fill_ppn;

    int checks = 0, errors = 0;
    logic [31:0] mem [logic [31:0]];
    int nrd = 0;
    logic [31:0] rd_log [4];
    bit mem_on = 0;

    page_walker uut (.*);

    always #5 clk = ~clk;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic bit allowed(input logic [1:0] r, input logic [1:0] a);
        case (a)
            2'b00: return r != 2'b00;
            2'b01: return r == 2'b10;
            2'b10: return r == 2'b11;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // memory model: ready random, one read at a time, latency 1..3
    initial begin
        bit pend = 0;
        int dly = 0;
        logic [31:0] pa = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (pend) begin
                if (dly == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = rd(pa);
                    pend = 0;
                end else dly--;
                mem_req_ready = 0;
            end else begin
                mem_req_ready = mem_on && ($urandom % 4 != 0);
                if (mem_req_valid && mem_req_ready) begin
                    pend = 1;
                    pa   = mem_req_addr;
                    dly  = $urandom % 3;
                    if (nrd < 4) rd_log[nrd] = mem_req_addr;
                    nrd++;
                end
            end
        end
    end

    // runs one walk against reference base rb and checks every output
    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [19:0] rb,
                        input bit poke_busy);
        logic [31:0] a1, a2, e1, e2;
        logic [1:0]  ek;
        int          en;
        bit          seen;
        a1 = {rb, va[31:22], 2'b00};
        e1 = rd(a1);
        a2 = {e1[31:12], va[21:12], 2'b00};
        e2 = rd(a2);
        if (!e1[0])                    begin ek = 2'b01; en = 1; end
        else if (!e2[0])               begin ek = 2'b10; en = 2; end
        else if (!allowed(e2[2:1], acc)) begin ek = 2'b11; en = 2; end
        else                           begin ek = 2'b00; en = 2; end
        nrd = 0;
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_access = acc;
        @(negedge clk);
        req_valid = 0;
        chk(busy == 1, "R9 busy after accept", busy, 1);
        if (poke_busy) begin
            req_valid = 1; req_vaddr = ~va; req_access = ~acc;
            @(negedge clk);
            req_valid = 0;
        end
        seen = 0;
        for (int i = 0; i < 200 && !seen; i++) begin
            if (res_valid) seen = 1;
            else @(negedge clk);
        end
        chk(seen, "R10 result arrives", seen, 1);
        if (!seen) return;
        chk(nrd == en, ek == 2'b01 ? "R4 read count" : "R5 read count", nrd, en);
        chk(rd_log[0] == a1, "R2 first address", rd_log[0], a1);
        if (en == 2) chk(rd_log[1] == a2, "R3 second address", rd_log[1], a2);
        chk(res_kind == ek, ek == 2'b11 ? "R6 kind" : (ek == 2'b01 ? "R4 kind" : "R5 kind"),
            res_kind, ek);
        chk(res_fault == (ek != 2'b00), "R6 fault flag", res_fault, ek != 2'b00);
        chk(fill_valid == (ek == 2'b00), "R10 fill only on success", fill_valid, ek == 2'b00);
        if (ek == 2'b00) begin
            chk(res_ppn == e2[31:12], "R7 ppn", res_ppn, e2[31:12]);
            chk(fill_vpn == va[31:12], "R7 fill vpn", fill_vpn, va[31:12]);
            chk(fill_ppn == e2[31:12], "R7 fill ppn", fill_ppn, e2[31:12]);
            chk(fill_rights == e2[2:1], "R7 fill rights", fill_rights, e2[2:1]);
        end
        @(negedge clk);
        chk(res_valid == 0, "R10 single pulse", res_valid, 0);
        chk(busy == 0, "R9 busy drops", busy, 0);
    endtask

    task automatic load_base(input logic [19:0] p);
        @(negedge clk);
        base_load = 1; base_page = p;
        @(negedge clk);
        base_load = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20050802));
        // tables: base 0x00010, L2 tables at 0x00100+i
        for (int i = 0; i < 8; i++) begin
            logic [31:0] l1;
            l1 = {20'h00100 + 20'(i), 9'd0, 2'($urandom), (i != 3) ? 1'b1 : 1'b0};
            mem[{20'h00010, 10'(i), 2'b00}] = l1;
            for (int j = 0; j < 16; j++)
                mem[{20'h00100 + 20'(i), 10'(j), 2'b00}] =
                    {20'($urandom), 9'd0, 2'($urandom), ($urandom % 4 != 0) ? 1'b1 : 1'b0};
        end
        // directed entries: L1 index 5 -> L2 table at 0x00105
        mem[{20'h00105, 10'd1, 2'b00}] = {20'hABCDE, 9'd0, 2'b10, 1'b1}; // read/write
        mem[{20'h00105, 10'd2, 2'b00}] = {20'h12345, 9'd0, 2'b01, 1'b1}; // read-only
        mem[{20'h00105, 10'd3, 2'b00}] = {20'h0BEEF, 9'd0, 2'b11, 1'b0}; // invalid
        mem[{20'h00105, 10'd4, 2'b00}] = {20'h0CAFE, 9'd0, 2'b11, 1'b1}; // read/exec
        // second process table at base 0x00020, index 5 -> table 0x00200
        mem[{20'h00020, 10'd5, 2'b00}] = {20'h00200, 9'd0, 2'b00, 1'b1};
        mem[{20'h00200, 10'd1, 2'b00}] = {20'h55555, 9'd0, 2'b01, 1'b1};

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(mem_req_valid == 0, "R1 mem_req_valid", mem_req_valid, 0);
        chk(res_valid == 0, "R1 res_valid", res_valid, 0);
        chk(fill_valid == 0, "R1 fill_valid", fill_valid, 0);
        mem_on = 1;
        // R1: base is page 0 after reset: empty memory gives L1 fault at address of page 0
        walk({10'd5, 10'd1, 12'h123}, 2'b00, 20'h0, 0);

        load_base(20'h00010);
        walk({10'd5, 10'd1, 12'h000}, 2'b01, 20'h00010, 0);   // R7 write to RW ok
        walk({10'd5, 10'd2, 12'h000}, 2'b00, 20'h00010, 0);   // R6 read RO ok
        walk({10'd5, 10'd2, 12'h000}, 2'b01, 20'h00010, 0);   // R6 write RO fault
        walk({10'd5, 10'd1, 12'h000}, 2'b10, 20'h00010, 0);   // R6 exec RW fault
        walk({10'd5, 10'd4, 12'h000}, 2'b10, 20'h00010, 0);   // R6 exec RX ok
        walk({10'd5, 10'd4, 12'h000}, 2'b11, 20'h00010, 0);   // R6 reserved fault
        walk({10'd5, 10'd3, 12'h000}, 2'b00, 20'h00010, 0);   // R5 leaf invalid
        walk({10'd3, 10'd0, 12'h000}, 2'b00, 20'h00010, 0);   // R4 root invalid
        walk({10'd9, 10'd0, 12'hFFF}, 2'b00, 20'h00010, 0);   // R4 unmapped root
        walk({10'd5, 10'd1, 12'h000}, 2'b00, 20'h00010, 1);   // R9 request during walk ignored
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk(!busy && !res_valid, "R9 ignored request leaves no walk", busy, 0);
        end

        // R8: process switch
        load_base(20'h00020);
        walk({10'd5, 10'd1, 12'h000}, 2'b00, 20'h00020, 0);
        // R8: reload during a walk keeps the old base for that walk
        fork
            walk({10'd5, 10'd1, 12'h000}, 2'b00, 20'h00020, 0);
            begin
                repeat (2) @(negedge clk);
                base_load = 1; base_page = 20'h00010;
                @(negedge clk);
                base_load = 0;
            end
        join
        walk({10'd5, 10'd1, 12'h000}, 2'b01, 20'h00010, 0);   // R8 new base now

        // random walks
        for (int n = 0; n < 300; n++) begin
            logic [31:0] va;
            va = {10'($urandom % 8), 10'($urandom % 16), 12'($urandom)};
            walk(va, 2'($urandom), 20'h00010, ($urandom % 5) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule